// File: doc/BRIEF.md
# Asynchronous-Bus DRAM Controller with Row Refresh

This block sits between an asynchronous memory bus and an array of DRAM devices arranged as several chip-select rows. A bus master places an address and a read/write level on the bus and raises its request. The controller passes the request through a two-flop synchroniser and captures the address. It then presents the row part of the address with RAS and, after a programmable delay, the column part with CAS. It answers with a memory-function-complete strobe once the data is valid, and holds that strobe until the master withdraws its request, which gives a four-phase handshake. Data lines run straight between the bus and the devices. The controller only steers addresses, strobes and selects.

A refresh timer raises a request at a fixed interval. The request stays pending until the controller grants it. Whenever the controller is idle and a refresh is pending, the refresh is started before any waiting bus access. A refresh cycle drives the refresh row counter onto the address pins and pulses RAS with every chip select low, so the write level that remains on the device R/W line cannot change any cell. The counter then advances to the next row. All timings are parameters counted in clock cycles.

Top module: `dram_bus_ctrl`

## Requirements
- R1: While reset is held, and at any time `busy` is low, `dram_ras`, `dram_cas` and `bus_mfc` are low and every bit of `dram_cs` is 0.
- R2: An accepted bus access first raises `dram_ras` with `dram_addr` equal to the row field, address bits [COL_W+ROW_W-1:COL_W], and with `busy` high.
- R3: `dram_cas` rises exactly T_RCD cycles after `dram_ras` rises, with `dram_addr` equal to the column field, address bits [COL_W-1:0]. `dram_cas` is never high while `dram_ras` is low.
- R4: `bus_mfc` rises exactly T_CAS cycles after `dram_cas` rises and is only high while both strobes are high. It stays high while `bus_req` is high, and falls on the third clock edge after `bus_req` falls.
- R5: `busy` is high from the first RAS of a cycle until its precharge ends, and no RAS pulse begins while a previous cycle is still in progress.
- R6: During CAS, `dram_we` is 1 for a write (`bus_rd` = 0) and 0 for a read. Data written at an address is read back unchanged, with refreshes interleaved.
- R7: The top CS_BITS address bits select one chip-select row: `dram_cs` bit i is 1 when that field equals i. At most one bit of `dram_cs` is ever 1.
- R8: A refresh request is raised every REF_INTERVAL cycles and remains pending until granted. While no bus traffic is present, refresh RAS pulses start exactly REF_INTERVAL cycles apart.
- R9: When a refresh and a bus request are both pending as the controller becomes idle, the refresh RAS pulse comes first and the access follows.
- R10: A refresh cycle holds `dram_ras` high for T_RAS cycles with `dram_cas` low and all of `dram_cs` 0.
- R11: The refresh row on `dram_addr[ROW_W-1:0]` starts at 0 after reset, advances by one after each refresh, and wraps modulo 2^ROW_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | CS_BITS+ROW_W+COL_W | Word address from the bus, held while `bus_req` is high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_req | input | 1 | Asynchronous memory request |
| bus_mfc | output | 1 | Memory function complete, held until `bus_req` falls |
| busy | output | 1 | A memory or refresh cycle is in progress |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column/refresh address |
| dram_ras | output | 1 | Row strobe, active high |
| dram_cas | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Device write level, 1 = write |
| dram_cs | output | 2^CS_BITS | Per-row chip selects, active high |

## Verification
The bound checker examines every cycle for the strobe and select invariants: CAS is never high without RAS, the chip selects are never more than one-hot, MFC is only high while both strobes are high and holds while the request is high, RAS starts only with busy high, refresh RAS never carries CAS, and the idle state is quiet. The cycle distances (RAS to CAS, CAS to MFC, request release to MFC release, refresh spacing and refresh RAS width) can only be measured by the bench scenarios. The same is true of the refresh row sequence and its wrap, of read-back data across a full sweep of a small address space, and of refresh winning a tie with a waiting request.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_DATA,
      ST_DONE,
      ST_REF_RAS,
      ST_REF_END
   } dc_state_e;

   typedef enum logic [1:0] {
      MUX_ROW,
      MUX_COL,
      MUX_REF
   } mux_sel_e;

endpackage

// File: rtl/dramc_refresh.sv
module dramc_refresh #(
   parameter int ROW_W    = 10,
   parameter int INTERVAL = 3900
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grant,
   input  logic             done,
   output logic             pend,
   output logic [ROW_W-1:0] row
);
   localparam int CW = $clog2(INTERVAL);

   if (INTERVAL < 4) begin : g_bad_interval
      $error("dramc_refresh: INTERVAL must be at least 4");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("dramc_refresh: ROW_W must be at least 1");
   end

   logic [CW-1:0] tmr;
   logic          tick;

   assign tick = (tmr == CW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr  <= '0;
         pend <= 1'b0;
         row  <= '0;
      end else begin
         tmr  <= tick ? '0 : tmr + 1'b1;
         pend <= tick | (pend & ~grant);
         if (done) row <= row + 1'b1;
      end
   end
endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux
   import dramc_pkg::*;
#(
   parameter int ROW_W = 10,
   parameter int COL_W = 10,
   parameter int MUX_W = 10
) (
   input  mux_sel_e         sel,
   input  logic [ROW_W-1:0] row_a,
   input  logic [COL_W-1:0] col_a,
   input  logic [ROW_W-1:0] ref_a,
   output logic [MUX_W-1:0] addr
);
   if (MUX_W < ROW_W || MUX_W < COL_W) begin : g_bad_width
      $error("dramc_addr_mux: MUX_W narrower than a field");
   end

   always_comb begin
      addr = '0;
      unique case (sel)
         MUX_COL: addr[COL_W-1:0] = col_a;
         MUX_REF: addr[ROW_W-1:0] = ref_a;
         default: addr[ROW_W-1:0] = row_a;
      endcase
   end
endmodule

// File: rtl/dramc_cs_decode.sv
module dramc_cs_decode #(
   parameter int CS_BITS = 2,
   parameter int N_CS    = 4
) (
   input  logic [CS_BITS-1:0] sel,
   input  logic               en,
   output logic [N_CS-1:0]    cs
);
   if (N_CS != (1 << CS_BITS)) begin : g_bad_count
      $error("dramc_cs_decode: N_CS must equal 2**CS_BITS");
   end

   for (genvar i = 0; i < N_CS; i++) begin : g_line
      assign cs[i] = en && (sel == CS_BITS'(i));
   end
endmodule

// File: rtl/dram_bus_ctrl.sv
module dram_bus_ctrl
   import dramc_pkg::*;
#(
   parameter int CS_BITS      = 2,
   parameter int ROW_W        = 10,
   parameter int COL_W        = 10,
   parameter int REF_INTERVAL = 3900,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 2,
   parameter int T_RAS        = 4,
   parameter int T_PRE        = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [CS_BITS+ROW_W+COL_W-1:0]            bus_addr,
   input  logic                                      bus_rd,
   input  logic                                      bus_req,
   output logic                                      bus_mfc,
   output logic                                      busy,
   output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
   output logic                                      dram_ras,
   output logic                                      dram_cas,
   output logic                                      dram_we,
   output logic [(1 << CS_BITS)-1:0]                 dram_cs
);
   localparam int ADDR_W = CS_BITS + ROW_W + COL_W;
   localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int N_CS   = 1 << CS_BITS;
   localparam int T_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
   localparam int T_B    = (T_RAS > T_PRE) ? T_RAS : T_PRE;
   localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
   localparam int TW     = $clog2(T_MAX + 1);

   if (CS_BITS < 1) begin : g_bad_cs
      $error("dram_bus_ctrl: CS_BITS must be at least 1");
   end
   if (T_RCD < 1 || T_CAS < 1 || T_RAS < 1 || T_PRE < 1) begin : g_bad_timing
      $error("dram_bus_ctrl: every timing must be at least one cycle");
   end

   dc_state_e         state, nstate;
   logic [TW-1:0]     tcnt;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic              req_m, req_s;
   logic              grant, ref_done, capture, ref_pend, cs_en;
   logic [ROW_W-1:0]  ref_row;
   mux_sel_e          mux_sel;

   // Access control and timing control, one machine.
   always_comb begin
      nstate   = state;
      grant    = 1'b0;
      ref_done = 1'b0;
      capture  = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (ref_pend) begin
               nstate = ST_REF_RAS;
               grant  = 1'b1;
            end else if (req_s) begin
               nstate  = ST_ROW;
               capture = 1'b1;
            end
         end
         ST_ROW:     if (tcnt == TW'(T_RCD - 1)) nstate = ST_COL;
         ST_COL:     if (tcnt == TW'(T_CAS - 1)) nstate = ST_DATA;
         ST_DATA:    if (!req_s) nstate = ST_DONE;
         ST_DONE:    if (tcnt == TW'(T_PRE - 1)) nstate = ST_IDLE;
         ST_REF_RAS: if (tcnt == TW'(T_RAS - 1)) nstate = ST_REF_END;
         ST_REF_END: begin
            if (tcnt == TW'(T_PRE - 1)) begin
               nstate   = ST_IDLE;
               ref_done = 1'b1;
            end
         end
         default:    nstate = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         tcnt   <= '0;
         addr_q <= '0;
         rd_q   <= 1'b1;
         req_m  <= 1'b0;
         req_s  <= 1'b0;
      end else begin
         state <= nstate;
         tcnt  <= (nstate != state) ? '0 : tcnt + 1'b1;
         req_m <= bus_req;
         req_s <= req_m;
         if (capture) begin
            addr_q <= bus_addr;
            rd_q   <= bus_rd;
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_COL, ST_DATA:        mux_sel = MUX_COL;
         ST_REF_RAS, ST_REF_END: mux_sel = MUX_REF;
         default:                mux_sel = MUX_ROW;
      endcase
   end

   assign dram_ras = (state == ST_ROW) || (state == ST_COL) ||
                     (state == ST_DATA) || (state == ST_REF_RAS);
   assign dram_cas = (state == ST_COL) || (state == ST_DATA);
   assign cs_en    = (state == ST_ROW) || (state == ST_COL) || (state == ST_DATA);
   assign bus_mfc  = (state == ST_DATA);
   assign busy     = (state != ST_IDLE);
   assign dram_we  = ~rd_q;

   dramc_refresh #(
      .ROW_W    (ROW_W),
      .INTERVAL (REF_INTERVAL)
   ) u_refresh (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (grant),
      .done  (ref_done),
      .pend  (ref_pend),
      .row   (ref_row)
   );

   dramc_addr_mux #(
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .MUX_W (MUX_W)
   ) u_mux (
      .sel   (mux_sel),
      .row_a (addr_q[COL_W +: ROW_W]),
      .col_a (addr_q[COL_W-1:0]),
      .ref_a (ref_row),
      .addr  (dram_addr)
   );

   dramc_cs_decode #(
      .CS_BITS (CS_BITS),
      .N_CS    (N_CS)
   ) u_cs (
      .sel (addr_q[ADDR_W-1 -: CS_BITS]),
      .en  (cs_en),
      .cs  (dram_cs)
   );
endmodule

// File: rtl/dram_bus_ctrl_chk.sv
module dram_bus_ctrl_chk #(
   parameter int N_CS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_req,
   input logic            bus_mfc,
   input logic            busy,
   input logic            dram_ras,
   input logic            dram_cas,
   input logic [N_CS-1:0] dram_cs
);
   // R1
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!dram_ras && !dram_cas && !bus_mfc && dram_cs == '0));

   // R3
   cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dram_cas |-> dram_ras);

   // R4
   mfc_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_mfc |-> (dram_ras && dram_cas));

   // R4
   mfc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mfc && bus_req) |=> bus_mfc);

   // R5
   ras_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras) |-> busy);

   // R7
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dram_cs));

   // R10
   refresh_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_ras && dram_cs == '0) |-> !dram_cas);
endmodule

bind dram_bus_ctrl dram_bus_ctrl_chk #(.N_CS(N_CS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_mfc  (bus_mfc),
   .busy     (busy),
   .dram_ras (dram_ras),
   .dram_cas (dram_cas),
   .dram_cs  (dram_cs)
);

// File: tb/sim_dram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_dram_bus_ctrl;
   localparam int CSB = 2;
   localparam int RW  = 3;
   localparam int CW  = 3;
   localparam int P   = 60;
   localparam int RCD = 2;
   localparam int CAS = 2;
   localparam int RAS = 3;
   localparam int PRE = 3;
   localparam int AW  = CSB + RW + CW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] bus_addr;
   logic          bus_rd, bus_req;
   logic          bus_mfc, busy, dram_ras, dram_cas, dram_we;
   logic [2:0]    dram_addr;
   logic [3:0]    dram_cs;
   logic [15:0]   wdata;

   always #2 clk = ~clk;

   dram_bus_ctrl #(
      .CS_BITS(CSB), .ROW_W(RW), .COL_W(CW), .REF_INTERVAL(P),
      .T_RCD(RCD), .T_CAS(CAS), .T_RAS(RAS), .T_PRE(PRE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_req(bus_req), .bus_mfc(bus_mfc), .busy(busy),
      .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas),
      .dram_we(dram_we), .dram_cs(dram_cs)
   );

   function automatic logic [1:0] cs_idx(input logic [3:0] c);
      for (int i = 0; i < 4; i++) if (c[i]) return 2'(i);
      return 2'd0;
   endfunction

   function automatic logic [15:0] pat(input logic [7:0] a);
      return {a ^ 8'hA5, ~a};
   endfunction

   // Behavioural DRAM array and monitor.
   logic [15:0] mem [0:255];
   logic [2:0]  row_lat = '0;
   wire  [15:0] rdata = mem[{cs_idx(dram_cs), row_lat, dram_addr}];

   int         cyc = 0, ref_count = 0, acc_count = 0;
   int         last_ref_cyc = 0, ref_gap = 0, ras_cyc = 0, cas_cyc = 0, mfc_cyc = 0;
   int         mon_checks = 0, mon_fails = 0;
   logic       ras_q = 0, cas_q = 0, mfc_q = 0, ras_is_ref = 0;
   logic [2:0] exp_ref = '0, row_seen = '0, col_seen = '0;
   logic [3:0] cs_seen = '0;
   logic       we_seen = 0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (dram_ras && !ras_q) begin
            if (dram_cs == 4'b0) begin
               mon_checks++;
               if (dram_addr != exp_ref) begin
                  mon_fails++;
                  $display("FAIL R11 refresh row actual=%0d expected=%0d", dram_addr, exp_ref);
               end
               exp_ref      = exp_ref + 3'd1;
               ref_gap      = cyc - last_ref_cyc;
               last_ref_cyc = cyc;
               ref_count++;
               ras_is_ref   = 1'b1;
            end else begin
               row_lat    = dram_addr;
               row_seen   = dram_addr;
               cs_seen    = dram_cs;
               ras_cyc    = cyc;
               acc_count++;
               ras_is_ref = 1'b0;
            end
         end
         if (!dram_ras && ras_q && ras_is_ref) begin
            mon_checks++;
            if (cyc - last_ref_cyc != RAS) begin
               mon_fails++;
               $display("FAIL R10 refresh RAS width actual=%0d expected=%0d", cyc - last_ref_cyc, RAS);
            end
         end
         if (dram_cas && !cas_q) begin
            col_seen = dram_addr;
            we_seen  = dram_we;
            cas_cyc  = cyc;
            if (dram_we && dram_cs != 4'b0)
               mem[{cs_idx(dram_cs), row_lat, dram_addr}] = wdata;
         end
         if (bus_mfc && !mfc_q) mfc_cyc = cyc;
         if (dram_ras && dram_cs == 4'b0 && dram_cas) begin
            mon_fails++;
            $display("FAIL R10 CAS during refresh actual=1 expected=0");
         end
      end
      ras_q = dram_ras;
      cas_q = dram_cas;
      mfc_q = bus_mfc;
   end

   int tb_checks = 0, tb_fails = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tb_checks++;
      if (!ok) begin
         tb_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_access(input logic [7:0] a, input logic rd, input logic [15:0] wd,
                            output logic [15:0] got);
      int n;
      @(negedge clk);
      bus_addr = a; bus_rd = rd; wdata = wd; bus_req = 1'b1;
      while (!bus_mfc) @(negedge clk);
      @(negedge clk);
      got = rdata;
      check(row_seen == a[5:3], "R2 row field", row_seen, a[5:3]);
      check(cs_seen == (4'b1 << a[7:6]), "R7 chip select", cs_seen, 4'b1 << a[7:6]);
      check(col_seen == a[2:0], "R3 column field", col_seen, a[2:0]);
      check(cas_cyc - ras_cyc == RCD, "R3 RAS to CAS", cas_cyc - ras_cyc, RCD);
      check(mfc_cyc - cas_cyc == CAS, "R4 CAS to MFC", mfc_cyc - cas_cyc, CAS);
      check(we_seen == !rd, "R6 write level", we_seen, !rd);
      check(busy == 1'b1, "R5 busy in cycle", busy, 1);
      check(bus_mfc == 1'b1, "R4 MFC held", bus_mfc, 1);
      bus_req = 1'b0;
      n = 0;
      while (bus_mfc) begin @(negedge clk); n++; end
      check(n == 3, "R4 MFC release", n, 3);
      while (busy) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      int rc, ac;
      rst_n = 1'b0; bus_req = 1'b0; bus_rd = 1'b1; bus_addr = '0; wdata = '0;
      repeat (4) @(negedge clk);
      // R1 during reset
      check(!dram_ras && !dram_cas && !bus_mfc && !busy && dram_cs == 4'b0,
            "R1 reset outputs", {dram_ras, dram_cas, bus_mfc, busy, dram_cs}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!dram_ras && !dram_cas && !bus_mfc && !busy && dram_cs == 4'b0,
            "R1 idle outputs", {dram_ras, dram_cas, bus_mfc, busy, dram_cs}, 0);

      // R8: idle refresh spacing
      for (int k = 0; k < 3; k++) begin
         rc = ref_count;
         while (ref_count == rc) @(negedge clk);
         if (k > 0) check(ref_gap == P, "R8 refresh spacing", ref_gap, P);
      end

      // R6 R11: full write sweep then read-back sweep, refreshes interleave
      for (int a = 0; a < 256; a++) do_access(8'(a), 1'b0, pat(8'(a)), v);
      for (int a = 0; a < 256; a++) begin
         do_access(8'(a), 1'b1, 16'h0, v);
         check(v == pat(8'(a)), "R6 read-back", v, pat(8'(a)));
      end
      check(ref_count > 8, "R11 counter wrapped", ref_count, 9);

      // R9: refresh wins a tie with a waiting request
      @(negedge clk);
      bus_addr = 8'h2D; bus_rd = 1'b1; bus_req = 1'b1;
      while (!bus_mfc) @(negedge clk);
      repeat (P + 5) @(negedge clk);
      bus_req = 1'b0;
      while (bus_mfc) @(negedge clk);
      bus_addr = 8'hB6; bus_rd = 1'b1; bus_req = 1'b1;
      rc = ref_count; ac = acc_count;
      while (ref_count == rc && acc_count == ac) @(negedge clk);
      check(ref_count != rc && acc_count == ac, "R9 refresh first", acc_count - ac, 0);
      while (!bus_mfc) @(negedge clk);
      @(negedge clk);
      check(rdata == pat(8'hB6), "R9 access after refresh", rdata, pat(8'hB6));
      bus_req = 1'b0;
      while (busy) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", tb_checks + mon_checks, tb_fails + mon_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tb_checks + mon_checks + 1, tb_fails + mon_fails + 1);
      $finish;
   end
endmodule